// File: doc/BRIEF.md
# Capture / Compare / Pulse-Width Unit

This peripheral owns one 16-bit data register and a 4-bit mode field, and uses the register in one of three ways. In capture modes it copies a free-running 16-bit event timer into the register when a qualified edge arrives on the input pin. The pin is synchronized first, and edges can be divided down by 4 or 16 before they capture. In compare modes it watches for the event timer equal to the register. On a match it sets the interrupt flag and then drives the output pin high, drives it low, leaves it alone, or pulses a reset request back to the event timer.

In pulse-width modes the low byte of the register and two spare control bits form a 10-bit duty value. This value is compared against a 10-bit count made of an 8-bit period timer and its 2-bit phase. The duty value is double-buffered and takes effect only when the period timer wraps. Software reaches the unit through a byte-wide register bus with four addresses: control, data low, data high and status. The timers and the period-wrap strobe come from outside the block.

Top module: `ccp_unit`

## Requirements
- R1: After reset, control, data low, data high and status all read 0x00, pin_out is 0 and timer_reset is 0. Control bits 7:6 always read 0, whatever was written to them.
- R2: Register map, selected by bus_addr: 0 is control {2'b00, duty_lsb[1:0] at bits 5:4, mode[3:0] at bits 3:0}, 1 is data bits 7:0, 2 is data bits 15:8, and 3 is status with the flag at bit 0. Writes take effect at the clock edge where bus_wr is high. Reads are combinational.
- R3: Mode 0101 captures on each rising edge of pin_in and mode 0100 on each falling edge. Only the selected edge captures. The pin passes through two flops, so a change settled before clock edge k captures the cc_timer value present at edge k+2 and sets the flag at that edge.
- R4: Mode 0110 captures on every 4th rising edge and mode 0111 on every 16th. Any write to the control register restarts the edge count from zero.
- R5: In compare modes (10xx), a cycle with cc_timer equal to the 16-bit data register sets the flag at that clock edge. Mode 1000 sets pin_out to 1 and mode 1001 sets it to 0. Control bits 5:4 do not affect the match.
- R6: Mode 1010 sets the flag on a match and leaves pin_out unchanged. Mode 1011 sets the flag and raises timer_reset for exactly the cycle after each matching cycle.
- R7: In modes 11xx, pin_out is 1 while the count {pwm_timer, pwm_phase} is less than the active 10-bit duty and 0 otherwise. The duty is formed as {data[7:0], control[5:4]}. A duty of 0 keeps the pin low.
- R8: The active duty loads from the written value only at a clock edge where pwm_wrap is high. A write in mid-period changes the pulse starting with the next period. Outside PWM modes the active duty is cleared.
- R9: Mode 0000, and the unused codes 0001 to 0011, turn the unit off. In these modes the edge count and the compare output latch are cleared, pin_out is 0, and the data register is kept.
- R10: The flag stays set until a status write with bit 0 equal to 0 clears it. A write with bit 0 equal to 1 has no effect. When a set and a clear land on the same edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| cc_timer | input | 16 | Free-running capture/compare timer |
| pwm_timer | input | 8 | Period timer value |
| pwm_phase | input | 2 | Period timer fractional phase bits |
| pwm_wrap | input | 1 | High in the last cycle of each period |
| pin_in | input | 1 | Asynchronous capture input |
| pin_out | output | 1 | Compare / pulse output |
| irq_flag | output | 1 | Sticky interrupt flag |
| timer_reset | output | 1 | Reset request to the capture/compare timer |

## Verification
The bench builds the unit with its default parameters: 8-bit bus bytes, a 16-bit data register and a two-flop input synchronizer. At this size the widest edge divider (16) takes only a few hundred cycles. A full 1024-count pulse period is short enough to measure several periods back to back, so each one's high time can be counted. This reaches the synchronizer latency exactly, the count restart on a control write, and the period-boundary duty load with a write in mid-period.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
  typedef enum logic [1:0] {
    KIND_OFF = 2'd0,
    KIND_CAP = 2'd1,
    KIND_CMP = 2'd2,
    KIND_PWM = 2'd3
  } ccp_kind_e;

  localparam logic [3:0] MODE_CAP_FALL = 4'b0100;
  localparam logic [3:0] MODE_CMP_SET  = 4'b1000;
  localparam logic [3:0] MODE_CMP_CLR  = 4'b1001;
  localparam logic [3:0] MODE_CMP_FLAG = 4'b1010;
  localparam logic [3:0] MODE_CMP_TRST = 4'b1011;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_DLO  = 2'd1;
  localparam logic [1:0] ADDR_DHI  = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  function automatic ccp_kind_e mode_kind(input logic [3:0] m);
    if (m[3:2] == 2'b11)      return KIND_PWM;
    else if (m[3:2] == 2'b10) return KIND_CMP;
    else if (m[3:2] == 2'b01) return KIND_CAP;
    else                      return KIND_OFF;
  endfunction
endpackage

// File: rtl/ccp_edge_sync.sv
module ccp_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] chain_q;
  logic [STAGES:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-1:0], pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];
  assign fall = ~chain_q[STAGES-1] & chain_q[STAGES];
endmodule

// File: rtl/ccp_prescale.sv
module ccp_prescale #(
  parameter int MAX_DIV = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       en,
  input  logic       edge_hit,
  input  logic [1:0] div_sel,
  output logic       fire
);
  localparam int CNT_W = $clog2(MAX_DIV);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] limit;

  always_comb begin
    case (div_sel)
      2'b10:   limit = CNT_W'(3);
      2'b11:   limit = CNT_W'(MAX_DIV - 1);
      default: limit = '0;
    endcase
    fire  = en & edge_hit & (cnt_q == limit);
    cnt_d = cnt_q;
    if (clr)                cnt_d = '0;
    else if (en && edge_hit) cnt_d = fire ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ccp_pwm.sv
module ccp_pwm #(
  parameter int TMR_W  = 8,
  parameter int FRAC_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    wrap,
  input  logic [TMR_W+FRAC_W-1:0] duty_shadow,
  input  logic [TMR_W-1:0]        tmr,
  input  logic [FRAC_W-1:0]       phase,
  output logic [TMR_W+FRAC_W-1:0] duty_act,
  output logic                    pwm_hi
);
  localparam int DUTY_W = TMR_W + FRAC_W;

  logic [DUTY_W-1:0] duty_q;
  logic [DUTY_W-1:0] duty_d;
  logic [DUTY_W-1:0] count;

  always_comb begin
    duty_d = duty_q;
    if (!en)       duty_d = '0;
    else if (wrap) duty_d = duty_shadow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) duty_q <= '0;
    else        duty_q <= duty_d;
  end

  assign count    = {tmr, phase};
  assign duty_act = duty_q;
  assign pwm_hi   = en & (count < duty_q);
endmodule

// File: rtl/ccp_unit.sv
module ccp_unit
  import ccp_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int DATA_W      = 2 * BYTE_W,
  parameter int SYNC_STAGES = 2,
  parameter int MAX_DIV     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] cc_timer,
  input  logic [BYTE_W-1:0] pwm_timer,
  input  logic [1:0]        pwm_phase,
  input  logic              pwm_wrap,
  input  logic              pin_in,
  output logic              pin_out,
  output logic              irq_flag,
  output logic              timer_reset
);
  localparam int FRAC_W = 2;
  localparam int DUTY_W = BYTE_W + FRAC_W;

  logic [3:0]        mode_q, mode_d;
  logic [1:0]        dlsb_q, dlsb_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              flag_q, flag_d;
  logic              latch_q, latch_d;
  logic              trst_q, trst_d;

  ccp_kind_e         kind;
  logic              wr_ctrl, wr_lo, wr_hi, wr_clr;
  logic              rise, fall, sel_edge, cap_fire;
  logic              match;
  logic [DUTY_W-1:0] duty_act;
  logic              pwm_hi;

  assign kind    = mode_kind(mode_q);
  assign wr_ctrl = bus_wr & (bus_addr == ADDR_CTRL);
  assign wr_lo   = bus_wr & (bus_addr == ADDR_DLO);
  assign wr_hi   = bus_wr & (bus_addr == ADDR_DHI);
  assign wr_clr  = bus_wr & (bus_addr == ADDR_STAT) & ~bus_wdata[0];

  ccp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (pin_in),
    .rise (rise),
    .fall (fall)
  );

  assign sel_edge = (mode_q == MODE_CAP_FALL) ? fall : rise;

  ccp_prescale #(.MAX_DIV(MAX_DIV)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (wr_ctrl | (kind != KIND_CAP)),
    .en      (kind == KIND_CAP),
    .edge_hit(sel_edge),
    .div_sel (mode_q[1:0]),
    .fire    (cap_fire)
  );

  ccp_pwm #(.TMR_W(BYTE_W), .FRAC_W(FRAC_W)) u_pwm (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (kind == KIND_PWM),
    .wrap       (pwm_wrap),
    .duty_shadow({data_q[BYTE_W-1:0], dlsb_q}),
    .tmr        (pwm_timer),
    .phase      (pwm_phase),
    .duty_act   (duty_act),
    .pwm_hi     (pwm_hi)
  );

  assign match = (kind == KIND_CMP) & (cc_timer == data_q);

  always_comb begin
    mode_d  = mode_q;
    dlsb_d  = dlsb_q;
    data_d  = data_q;
    latch_d = latch_q;
    if (wr_ctrl) begin
      mode_d = bus_wdata[3:0];
      dlsb_d = bus_wdata[5:4];
    end
    if (cap_fire) begin
      data_d = cc_timer;
    end else begin
      if (wr_lo) data_d[BYTE_W-1:0]      = bus_wdata;
      if (wr_hi) data_d[DATA_W-1:BYTE_W] = bus_wdata;
    end
    if (kind == KIND_OFF)                      latch_d = 1'b0;
    else if (match && mode_q == MODE_CMP_SET)  latch_d = 1'b1;
    else if (match && mode_q == MODE_CMP_CLR)  latch_d = 1'b0;
    flag_d = cap_fire | match | (flag_q & ~wr_clr);
    trst_d = match & (mode_q == MODE_CMP_TRST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      dlsb_q  <= '0;
      data_q  <= '0;
      flag_q  <= 1'b0;
      latch_q <= 1'b0;
      trst_q  <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      dlsb_q  <= dlsb_d;
      data_q  <= data_d;
      flag_q  <= flag_d;
      latch_q <= latch_d;
      trst_q  <= trst_d;
    end
  end

  always_comb begin
    case (bus_addr)
      ADDR_CTRL: bus_rdata = BYTE_W'({2'b00, dlsb_q, mode_q});
      ADDR_DLO:  bus_rdata = data_q[BYTE_W-1:0];
      ADDR_DHI:  bus_rdata = data_q[DATA_W-1:BYTE_W];
      default:   bus_rdata = BYTE_W'(flag_q);
    endcase
    case (kind)
      KIND_CMP: pin_out = latch_q;
      KIND_PWM: pin_out = pwm_hi;
      default:  pin_out = 1'b0;
    endcase
  end

  assign irq_flag    = flag_q;
  assign timer_reset = trst_q;
endmodule

// File: rtl/ccp_unit_chk.sv
module ccp_unit_chk #(
  parameter int BYTE_W = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [1:0]        bus_addr,
  input logic [BYTE_W-1:0] bus_wdata,
  input logic [BYTE_W-1:0] bus_rdata,
  input logic [DATA_W-1:0] cc_timer,
  input logic [BYTE_W-1:0] pwm_timer,
  input logic [1:0]        pwm_phase,
  input logic              pin_out,
  input logic              irq_flag,
  input logic              timer_reset,
  input logic [3:0]        mode_q,
  input logic [DATA_W-1:0] data_q,
  input logic              cap_fire,
  input logic [BYTE_W+1:0] duty_act
);
  assert_ctrl_top_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd0) |-> (bus_rdata[7:6] == 2'b00));

  assert_data_only_moves_on_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_fire && !(bus_wr && (bus_addr == 2'd1 || bus_addr == 2'd2))) |=> $stable(data_q));

  assert_trst_after_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    timer_reset |-> ($past(mode_q) == 4'b1011 && $past(cc_timer) == $past(data_q)));

  assert_pwm_low_past_duty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[3:2] == 2'b11 && {pwm_timer, pwm_phase} >= duty_act) |-> !pin_out);

  assert_off_pin_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[3:2] == 2'b00) |-> !pin_out);

  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !(bus_wr && bus_addr == 2'd3 && !bus_wdata[0])) |=> irq_flag);
endmodule

bind ccp_unit ccp_unit_chk #(.BYTE_W(BYTE_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .cc_timer   (cc_timer),
  .pwm_timer  (pwm_timer),
  .pwm_phase  (pwm_phase),
  .pin_out    (pin_out),
  .irq_flag   (irq_flag),
  .timer_reset(timer_reset),
  .mode_q     (mode_q),
  .data_q     (data_q),
  .cap_fire   (cap_fire),
  .duty_act   (duty_act)
);

// File: tb/tb_ccp_unit.sv
module tb_ccp_unit;
  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic [1:0]  bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic [15:0] cc_timer;
  logic [7:0]  pwm_timer;
  logic [1:0]  pwm_phase;
  logic        pwm_wrap;
  logic        pin_in;
  logic        pin_out;
  logic        irq_flag;
  logic        timer_reset;

  int checks;
  int failures;
  bit done;

  ccp_unit dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cc_timer(cc_timer),
    .pwm_timer(pwm_timer), .pwm_phase(pwm_phase), .pwm_wrap(pwm_wrap),
    .pin_in(pin_in), .pin_out(pin_out), .irq_flag(irq_flag),
    .timer_reset(timer_reset)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_pin();
    pin_in = 1'b1; cycles(4);
    pin_in = 1'b0; cycles(4);
  endtask

  task automatic read_data(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(2'd1, lo); rd(2'd2, hi);
    v = {hi, lo};
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(2'd0, v); check("R1 ctrl", v, 0);
    rd(2'd1, v); check("R1 data lo", v, 0);
    rd(2'd2, v); check("R1 data hi", v, 0);
    rd(2'd3, v); check("R1 status", v, 0);
    check("R1 pin_out", pin_out, 0);
    check("R1 timer_reset", timer_reset, 0);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    wr(2'd0, 8'hF0);
    rd(2'd0, v); check("R1 R2 ctrl top bits zero", v, 8'h30);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h3C); wr(2'd2, 8'hC3);
    rd(2'd1, v); check("R2 data lo", v, 8'h3C);
    rd(2'd2, v); check("R2 data hi", v, 8'hC3);
    check("R9 off pin low", pin_out, 0);
  endtask

  task automatic t_capture();
    logic [15:0] d;
    logic [7:0] v;
    wr(2'd0, 8'h05);
    cc_timer = 16'hA5A5;
    @(negedge clk); pin_in = 1'b1;
    cycles(2); check("R3 latency not yet", irq_flag, 0);
    cycles(1); check("R3 latency flag", irq_flag, 1);
    read_data(d); check("R3 rising capture", d, 16'hA5A5);
    wr(2'd3, 8'h01);
    rd(2'd3, v); check("R10 write one ignored", v, 1);
    wr(2'd3, 8'h00);
    rd(2'd3, v); check("R10 cleared", v, 0);
    wr(2'd0, 8'h04);
    cc_timer = 16'h5A5A;
    pin_in = 1'b0; cycles(4);
    read_data(d); check("R3 falling capture", d, 16'h5A5A);
    check("R3 falling flag", irq_flag, 1);
    wr(2'd3, 8'h00);
    cc_timer = 16'h1111;
    pin_in = 1'b1; cycles(4);
    check("R3 rising ignored in falling mode flag", irq_flag, 0);
    read_data(d); check("R3 rising ignored data", d, 16'h5A5A);
    pin_in = 1'b0; cycles(4);
    wr(2'd3, 8'h00);
  endtask

  task automatic t_prescale();
    logic [15:0] d;
    wr(2'd0, 8'h06);
    for (int i = 0; i < 3; i++) begin
      cc_timer = 16'h0100 + 16'(i); pulse_pin();
    end
    check("R4 /4 no capture after 3", irq_flag, 0);
    cc_timer = 16'h0400; pulse_pin();
    check("R4 /4 flag on 4th", irq_flag, 1);
    read_data(d); check("R4 /4 data", d, 16'h0400);
    wr(2'd3, 8'h00);
    pulse_pin(); pulse_pin();
    wr(2'd0, 8'h06);
    for (int i = 0; i < 3; i++) pulse_pin();
    check("R4 restart after ctrl write", irq_flag, 0);
    cc_timer = 16'h0777; pulse_pin();
    check("R4 restart 4th", irq_flag, 1);
    wr(2'd3, 8'h00);
    wr(2'd0, 8'h07);
    for (int i = 0; i < 15; i++) pulse_pin();
    check("R4 /16 none after 15", irq_flag, 0);
    cc_timer = 16'h1616; pulse_pin();
    check("R4 /16 flag", irq_flag, 1);
    read_data(d); check("R4 /16 data", d, 16'h1616);
    wr(2'd3, 8'h00);
  endtask

  task automatic t_compare();
    wr(2'd1, 8'h34); wr(2'd2, 8'h12);
    cc_timer = 16'h1233;
    wr(2'd0, 8'h38);
    cycles(2);
    check("R5 no match no flag", irq_flag, 0);
    check("R5 pin before match", pin_out, 0);
    cc_timer = 16'h1234; @(negedge clk);
    cc_timer = 16'h1235;
    check("R5 set on match pin", pin_out, 1);
    check("R5 flag on match", irq_flag, 1);
    wr(2'd3, 8'h00);
    wr(2'd0, 8'h09);
    check("R5 pin held before clear match", pin_out, 1);
    cc_timer = 16'h1234; @(negedge clk);
    cc_timer = 16'h0000;
    check("R5 clear on match pin", pin_out, 0);
    wr(2'd3, 8'h00);
    wr(2'd0, 8'h08);
    cc_timer = 16'h1234; @(negedge clk); cc_timer = 16'h0000;
    wr(2'd3, 8'h00);
    wr(2'd0, 8'h0A);
    cc_timer = 16'h1234; @(negedge clk); cc_timer = 16'h0000;
    check("R6 flag only pin unchanged", pin_out, 1);
    check("R6 flag only flag", irq_flag, 1);
    check("R6 no timer reset in 1010", timer_reset, 0);
    wr(2'd3, 8'h00);
    wr(2'd0, 8'h0B);
    cc_timer = 16'h1234; @(negedge clk); cc_timer = 16'h0000;
    check("R6 timer_reset pulse", timer_reset, 1);
    check("R6 special flag", irq_flag, 1);
    @(negedge clk);
    check("R6 timer_reset one cycle", timer_reset, 0);
    wr(2'd3, 8'h00);
    wr(2'd0, 8'h00);
    check("R9 off clears latch", pin_out, 0);
    wr(2'd0, 8'h08);
    check("R9 latch cleared after off", pin_out, 0);
    wr(2'd0, 8'h00);
  endtask

  task automatic pwm_period(input bit mid_wr, input logic [7:0] lo,
                            input logic [7:0] ctl, output int high);
    high = 0;
    for (int c = 0; c < 1024; c++) begin
      @(negedge clk);
      pwm_timer = 8'(c >> 2); pwm_phase = 2'(c); pwm_wrap = (c == 1023);
      bus_wr = 1'b0;
      if (mid_wr && c == 500) begin bus_addr = 2'd1; bus_wdata = lo; bus_wr = 1'b1; end
      if (mid_wr && c == 501) begin bus_addr = 2'd0; bus_wdata = ctl; bus_wr = 1'b1; end
      #2 if (pin_out) high++;
    end
    @(negedge clk); bus_wr = 1'b0;
    pwm_wrap = 1'b0; pwm_timer = 8'd0; pwm_phase = 2'd0;
  endtask

  task automatic t_pwm();
    int h;
    wr(2'd1, 8'h40);
    wr(2'd0, 8'h1C);
    pwm_period(1'b0, 8'h00, 8'h00, h);
    check("R8 first period before wrap low", h, 0);
    pwm_period(1'b1, 8'h80, 8'h3C, h);
    check("R7 duty 257 high count", h, 257);
    pwm_period(1'b0, 8'h00, 8'h00, h);
    check("R8 new duty next period", h, 515);
    wr(2'd1, 8'h00); wr(2'd0, 8'h0C);
    pwm_period(1'b0, 8'h00, 8'h00, h);
    pwm_period(1'b0, 8'h00, 8'h00, h);
    check("R7 zero duty low", h, 0);
    wr(2'd0, 8'h00);
  endtask

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = 8'd0;
    cc_timer = 16'd0; pwm_timer = 8'd0; pwm_phase = 2'd0; pwm_wrap = 1'b0;
    pin_in = 1'b0;
    cycles(3);
    rst_n = 1'b1;
    cycles(2);
    t_reset();
    t_regs();
    t_capture();
    t_prescale();
    t_compare();
    t_pwm();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule